// File: doc/BRIEF.md
# Predicated Vector Splice Unit

The unit builds a result vector from two source vectors made of 16-bit lanes, steered by a predicate that carries one bit per lane (bit i controls lane i). It locates the lowest and the highest lane whose predicate bit is set. It then takes every lane of the first source from the lower bound to the upper bound, both included, and packs that run into the bottom of the result. Lanes between the bounds are copied even when their own predicate bit is clear. The result lanes above the packed run are filled in ascending order with the second source, starting at that source's lane 0.

The vector width is a parameter from 128 to 2048 bits, which gives 8 to 128 lanes. Each operation is presented with a valid strobe. One cycle later the result appears on a registered output with its own valid strobe. A new operation can be accepted on every cycle, so operations can stream back to back.

Top module: `vsplice_unit`

## Requirements
- R1: For a non-empty predicate with lowest set bit f and highest set bit l, result lanes 0 to l-f hold first-source lanes f to l in their original order.
- R2: Every first-source lane between f and l is copied, whether or not its own predicate bit is set.
- R3: Result lanes from l-f+1 up to the top hold second-source lanes 0, 1, 2, ... in ascending order.
- R4: When no predicate bit is set, the result equals the second source unchanged.
- R5: When every predicate bit is set, the result equals the first source unchanged.
- R6: When exactly one predicate bit k is set, result lane 0 holds first-source lane k, and the lanes above it hold second-source lanes from lane 0 upward.
- R7: `out_valid` is high in the cycle after a cycle with `in_valid` high, and `out_vec` then holds that operation's result.
- R8: Operations presented on consecutive cycles each produce their own result on consecutive cycles.
- R9: While reset is held and after it is released, `out_valid` is low until an operation is accepted.
- R10: A cycle with `in_valid` low gives `out_valid` low in the following cycle, and `out_vec` keeps its previous value.
- R11: The behaviour in R1 to R10 holds at the smallest width (128 bits) and at the largest width (2048 bits).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; asserts asynchronously and releases synchronously inside the unit |
| in_valid | input | 1 | Qualifies an operation on the inputs in this cycle |
| in_pred | input | VEC_BITS/16 | Predicate; bit i controls lane i |
| in_src_a | input | VEC_BITS | First source; the segment is taken from this vector |
| in_src_b | input | VEC_BITS | Second source; fills the lanes above the segment |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| out_vec | output | VEC_BITS | Registered result vector |

## Verification
Every result is due exactly one clock edge after the cycle in which its operation is driven. The bench changes inputs on the falling edge and reads `out_valid` and `out_vec` on the next falling edge, half a period after the capturing rising edge. In streaming runs, the result of operation n is read on the same falling edge that drives operation n+1. Idle checks read the outputs one falling edge after `in_valid` drops.

// File: rtl/vsplice_pkg.sv
package vsplice_pkg;
  localparam int LANE_W = 16;

  function automatic int lanes_of(input int vec_bits);
    return vec_bits / LANE_W;
  endfunction

  function automatic int cnt_width(input int lanes);
    return $clog2(lanes) + 1;
  endfunction
endpackage

// File: rtl/vsplice_bounds.sv
module vsplice_bounds
  import vsplice_pkg::*;
#(
  parameter int NUM_LANES = 16,
  localparam int CNT_W = cnt_width(NUM_LANES)
) (
  input  logic [NUM_LANES-1:0] pred,
  output logic [CNT_W-1:0]     first_idx,
  output logic [CNT_W-1:0]     seg_len,
  output logic                 any_set
);
  logic [CNT_W-1:0] last_idx;

  // lowest set lane: scan downward so the last hit wins
  always_comb begin
    first_idx = '0;
    for (int i = NUM_LANES - 1; i >= 0; i--) begin
      if (pred[i]) first_idx = CNT_W'(i);
    end
  end

  // highest set lane: scan upward so the last hit wins
  always_comb begin
    last_idx = '0;
    for (int i = 0; i < NUM_LANES; i++) begin
      if (pred[i]) last_idx = CNT_W'(i);
    end
  end

  always_comb begin
    any_set = |pred;
    seg_len = any_set ? (last_idx - first_idx + CNT_W'(1)) : '0;
  end
endmodule

// File: rtl/vsplice_shifter.sv
module vsplice_shifter
  import vsplice_pkg::*;
#(
  parameter int VEC_BITS   = 256,
  parameter bit SHIFT_LEFT = 1'b0,
  localparam int NUM_LANES = lanes_of(VEC_BITS),
  localparam int CNT_W     = cnt_width(NUM_LANES)
) (
  input  logic [VEC_BITS-1:0] din,
  input  logic [CNT_W-1:0]    lanes,
  output logic [VEC_BITS-1:0] dout
);
  logic [VEC_BITS-1:0] stage [0:CNT_W];

  assign stage[0] = din;

  for (genvar s = 0; s < CNT_W; s++) begin : g_stage
    localparam int SH = (1 << s) * LANE_W;
    if (SH >= VEC_BITS) begin : g_flush
      assign stage[s+1] = lanes[s] ? '0 : stage[s];
    end else if (SHIFT_LEFT) begin : g_left
      assign stage[s+1] = lanes[s] ? (stage[s] << SH) : stage[s];
    end else begin : g_right
      assign stage[s+1] = lanes[s] ? (stage[s] >> SH) : stage[s];
    end
  end

  assign dout = stage[CNT_W];
endmodule

// File: rtl/vsplice_unit.sv
module vsplice_unit
  import vsplice_pkg::*;
#(
  parameter int VEC_BITS = 256,
  localparam int NUM_LANES = lanes_of(VEC_BITS),
  localparam int CNT_W     = cnt_width(NUM_LANES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [NUM_LANES-1:0] in_pred,
  input  logic [VEC_BITS-1:0]  in_src_a,
  input  logic [VEC_BITS-1:0]  in_src_b,
  output logic                 out_valid,
  output logic [VEC_BITS-1:0]  out_vec
);
  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // bounds of the active run
  logic [CNT_W-1:0] first_idx;
  logic [CNT_W-1:0] seg_len;
  logic             any_set;

  vsplice_bounds #(.NUM_LANES(NUM_LANES)) i_bounds (
    .pred      (in_pred),
    .first_idx (first_idx),
    .seg_len   (seg_len),
    .any_set   (any_set)
  );

  // segment moved down, second source moved up
  logic [VEC_BITS-1:0] seg_down;
  logic [VEC_BITS-1:0] fill_up;

  vsplice_shifter #(.VEC_BITS(VEC_BITS), .SHIFT_LEFT(1'b0)) i_seg_shift (
    .din   (in_src_a),
    .lanes (first_idx),
    .dout  (seg_down)
  );

  vsplice_shifter #(.VEC_BITS(VEC_BITS), .SHIFT_LEFT(1'b1)) i_fill_shift (
    .din   (in_src_b),
    .lanes (seg_len),
    .dout  (fill_up)
  );

  logic [VEC_BITS-1:0] seg_mask;
  for (genvar g = 0; g < NUM_LANES; g++) begin : g_mask
    assign seg_mask[g*LANE_W +: LANE_W] = (CNT_W'(g) < seg_len) ? '1 : '0;
  end

  logic [VEC_BITS-1:0] merged;
  assign merged = (seg_down & seg_mask) | fill_up;

  // next state
  logic                valid_d, valid_q;
  logic [VEC_BITS-1:0] data_d, data_q;
  logic                data_en;

  always_comb begin
    valid_d = in_valid;
    data_en = in_valid;
    data_d  = merged;
  end

  // registers
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) valid_q <= 1'b0;
    else            valid_q <= valid_d;
  end

  always_ff @(posedge clk) begin
    if (data_en) data_q <= data_d;
  end

  assign out_valid = valid_q;
  assign out_vec   = data_q;

  // checks
  assert_bounds_order_R1: assert property (@(posedge clk) disable iff (!rst_int_n)
    (in_valid && any_set) |-> (seg_len != '0 && (first_idx + seg_len) <= CNT_W'(NUM_LANES)));

  assert_empty_pred_R4: assert property (@(posedge clk) disable iff (!rst_int_n)
    (in_valid && in_pred == '0) |=> (out_vec == $past(in_src_b)));

  assert_full_pred_R5: assert property (@(posedge clk) disable iff (!rst_int_n)
    (in_valid && (&in_pred)) |=> (out_vec == $past(in_src_a)));

  assert_single_lane_R6: assert property (@(posedge clk) disable iff (!rst_int_n)
    (in_valid && $countones(in_pred) == 1) |-> (seg_len == CNT_W'(1)));

  assert_valid_follows_R7: assert property (@(posedge clk) disable iff (!rst_int_n)
    in_valid |=> out_valid);

  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_int_n)
    !in_valid |=> (!out_valid && $stable(out_vec)));
endmodule

// File: tb/test_vsplice_unit.sv
`timescale 1ns/1ps
module test_vsplice_unit;
  localparam int NL = 8;    // narrow lanes (128 bits)
  localparam int WL = 128;  // wide lanes (2048 bits)

  logic clk = 1'b0;
  always #2 clk = ~clk;     // 250 MHz

  logic            rst_n;
  logic            vin;
  logic [WL-1:0]   pred;
  logic [2047:0]   a, b;
  logic            vo_n, vo_w;
  logic [127:0]    q_n;
  logic [2047:0]   q_w;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  vsplice_unit #(.VEC_BITS(128)) i_vsplice_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(vin), .in_pred(pred[NL-1:0]),
    .in_src_a(a[127:0]), .in_src_b(b[127:0]), .out_valid(vo_n), .out_vec(q_n));

  vsplice_unit #(.VEC_BITS(2048)) i_vsplice_unit_w (
    .clk(clk), .rst_n(rst_n), .in_valid(vin), .in_pred(pred),
    .in_src_a(a), .in_src_b(b), .out_valid(vo_w), .out_vec(q_w));

  function automatic logic [2047:0] ref_splice(input logic [2047:0] sa, input logic [2047:0] sb,
                                               input logic [WL-1:0] p, input int n);
    logic [2047:0] r = '0;
    int lo = -1;
    int hi = -1;
    int k = 0;
    for (int i = 0; i < n; i++) if (p[i]) begin
      if (lo < 0) lo = i;
      hi = i;
    end
    if (lo >= 0) for (int i = lo; i <= hi; i++) begin
      r[k*16 +: 16] = sa[i*16 +: 16];
      k++;
    end
    for (int j = 0; k < n; j++) begin
      r[k*16 +: 16] = sb[j*16 +: 16];
      k++;
    end
    return r;
  endfunction

  function automatic logic [2047:0] rand_vec();
    logic [2047:0] v;
    for (int i = 0; i < 64; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  function automatic logic [WL-1:0] rand_pred();
    logic [WL-1:0] v;
    for (int i = 0; i < 4; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  task automatic check_bit(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic check_vec(input string req, input logic [2047:0] act, input logic [2047:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // expected results of the operation currently driven
  logic [2047:0] exp_n, exp_w;

  task automatic drive(input logic [WL-1:0] p, input logic [2047:0] sa, input logic [2047:0] sb);
    vin   = 1'b1;
    pred  = p;
    a     = sa;
    b     = sb;
    exp_n = ref_splice(sa, sb, p, NL);
    exp_w = ref_splice(sa, sb, p, WL);
  endtask

  task automatic check_out(input string req);
    check_bit({req, " R7 narrow valid"}, vo_n, 1'b1);
    check_bit({req, " R7 R11 wide valid"}, vo_w, 1'b1);
    check_vec({req, " narrow"}, {1920'b0, q_n}, exp_n);
    check_vec({req, " R11 wide"}, q_w, exp_w);
  endtask

  // called on a falling edge; leaves on a falling edge with vin low
  task automatic run_op(input string req, input logic [WL-1:0] p,
                        input logic [2047:0] sa, input logic [2047:0] sb);
    drive(p, sa, sb);
    @(negedge clk);
    check_out(req);
    vin = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; vin = 1'b0; pred = '0; a = '0; b = '0;
    repeat (3) @(negedge clk);
    check_bit("R9 narrow valid in reset", vo_n, 1'b0);
    check_bit("R9 wide valid in reset", vo_w, 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_bit("R9 narrow valid after release", vo_n, 1'b0);
    check_bit("R9 wide valid after release", vo_w, 1'b0);
  endtask

  task automatic t_empty();
    run_op("R4 empty predicate", '0, rand_vec(), rand_vec());
    check_vec("R4 wide equals second source", q_w, b);
  endtask

  task automatic t_full();
    run_op("R5 full predicate", '1, rand_vec(), rand_vec());
    check_vec("R5 wide equals first source", q_w, a);
  endtask

  task automatic t_single();
    run_op("R6 single lane 0", WL'(1), rand_vec(), rand_vec());
    run_op("R6 single lane 7", WL'(1) << 7, rand_vec(), rand_vec());
    run_op("R6 single lane 3", WL'(1) << 3, rand_vec(), rand_vec());
    run_op("R6 single lane 127", WL'(1) << 127, rand_vec(), rand_vec());
  endtask

  task automatic t_gap();
    // bits 2 and 5 only: lanes 3 and 4 are inactive yet still taken
    run_op("R2 gap inside run", WL'(8'b0010_0100), rand_vec(), rand_vec());
    run_op("R2 wide ends far apart", (WL'(1) << 100) | (WL'(1) << 9), rand_vec(), rand_vec());
  endtask

  task automatic t_random();
    for (int i = 0; i < 40; i++) run_op("R1 R3 random", rand_pred(), rand_vec(), rand_vec());
    for (int i = 0; i < 10; i++) run_op("R1 R3 sparse", rand_pred() & rand_pred() & rand_pred(),
                                        rand_vec(), rand_vec());
  endtask

  task automatic t_stream();
    drive(rand_pred(), rand_vec(), rand_vec());
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      check_out("R8 back-to-back");
      drive(rand_pred(), rand_vec(), rand_vec());
    end
    @(negedge clk);
    check_out("R8 back-to-back last");
    vin = 1'b0;
  endtask

  task automatic t_idle();
    logic [127:0]  held_n;
    logic [2047:0] held_w;
    run_op("R10 setup", rand_pred(), rand_vec(), rand_vec());
    held_n = q_n;
    held_w = q_w;
    pred = rand_pred(); a = rand_vec(); b = rand_vec();
    for (int i = 0; i < 2; i++) begin
      @(negedge clk);
      check_bit("R10 narrow valid idle", vo_n, 1'b0);
      check_bit("R10 wide valid idle", vo_w, 1'b0);
      check_vec("R10 narrow held", {1920'b0, q_n}, {1920'b0, held_n});
      check_vec("R10 wide held", q_w, held_w);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_empty();
    t_full();
    t_single();
    t_gap();
    t_random();
    t_stream();
    t_idle();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule